// File: doc/BRIEF.md
# Packed Byte Lane Shifter

This execution unit takes one packed data word and shifts every 8-bit lane of it by the same amount, with each lane handled on its own. The operation select picks one of eight shift kinds:

- arithmetic right shift and logical right shift, each with or without rounding;
- plain left shift;
- saturating left shift;
- a signed-amount shift, with or without rounding, whose direction comes from the sign of a 4-bit amount.

The shift amount comes either from the low bits of the second operand word or from a 3-bit immediate. The result is registered once. A valid output marks the cycle in which the result is fresh.

Every lane that overflows during a saturating left shift raises a sticky saturation flag. The flag stays set until the surrounding logic pulses the clear input. The data width is a parameter, 32 or 64 bits, giving 4 or 8 lanes.

Top module: `byte_lane_shifter`

## Requirements
- R1: `out_valid` equals `in_valid` delayed by one clock. `result` loads on a clock with `in_valid` high and holds its value otherwise. Reset drives `out_valid`, `result` and `sat_flag` to zero.
- R2: The encoding of `op` is:

  | `op` | Operation |
  |---|---|
  | 000 | arithmetic right |
  | 001 | rounding arithmetic right |
  | 010 | logical right |
  | 011 | rounding logical right |
  | 100 | left |
  | 101 | saturating left |
  | 110 | signed-amount |
  | 111 | rounding signed-amount |

  For the codes 000 to 101, the amount is `rs2[2:0]`, or `imm_amt` when `use_imm` is 1. The same amount applies to every lane.
- R3: Arithmetic right shift fills each lane with that lane's bit 7. Logical right shift and left shift fill with zeros. Bits moved past a lane edge are lost.
- R4: A rounding right shift gives the truncated lane result plus the last bit shifted out of the lane. An amount of 0 returns the lane unchanged.
- R5: A saturating left shift overflows when the value shifted back does not equal the input lane, which means the amount exceeds the lane's redundant sign bits. An overflowing lane becomes 8'h80 if its input was negative and 8'h7F otherwise.
- R6: The signed-amount shift reads `rs2[3:0]` as a value from -8 to +7 and ignores `use_imm`. Zero or a positive value gives the saturating left shift of R5. A negative value gives an arithmetic right shift by its magnitude, and -8 shifts right by 7.
- R7: The rounding signed-amount shift uses the rounding arithmetic right shift of R4 for negative amounts. For zero and positive amounts it uses the saturating left shift of R5.
- R8: `sat_flag` is set one clock after an accepted operation in which any lane overflowed. It stays set until a clock with `sat_clr` high. An overflow accepted on that same clock leaves the flag set.
- R9: Operation codes 000 to 100 never set `sat_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands and op are valid this cycle |
| op | input | 3 | Operation select, encoding in R2 |
| use_imm | input | 1 | Take the amount from `imm_amt` instead of `rs2` |
| imm_amt | input | 3 | Immediate shift amount |
| rs1 | input | DATA_W | Packed byte lanes to shift |
| rs2 | input | DATA_W | Shift amount word, low 3 or 4 bits used |
| sat_clr | input | 1 | Clears the saturation flag |
| out_valid | output | 1 | Result register was loaded on the last clock |
| result | output | DATA_W | Packed shifted lanes |
| sat_flag | output | 1 | Sticky saturation flag |

## Verification
The saturation flag can receive a clear and a new overflow on the same clock. The bench provokes this by pulsing `sat_clr` together with an overflowing saturating left shift, and expects the flag to stay set. It also pulses `sat_clr` together with a non-overflowing operation, and expects the flag to drop. Random traffic also pulses the clear on about one operation in eight. A bench model of the flag, which clears first and then ORs in the reference overflow, judges every one of these cases.

// File: rtl/byte_lane_shifter.sv
module byte_lane_shifter #(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [2:0]        op,
  input  logic              use_imm,
  input  logic [2:0]        imm_amt,
  input  logic [DATA_W-1:0] rs1,
  input  logic [DATA_W-1:0] rs2,
  input  logic              sat_clr,
  output logic              out_valid,
  output logic [DATA_W-1:0] result,
  output logic              sat_flag
);
  localparam int LANES = DATA_W / 8;

  localparam logic [2:0] OP_SRA     = 3'd0;
  localparam logic [2:0] OP_SRA_RND = 3'd1;
  localparam logic [2:0] OP_SRL     = 3'd2;
  localparam logic [2:0] OP_SRL_RND = 3'd3;
  localparam logic [2:0] OP_SLL     = 3'd4;
  localparam logic [2:0] OP_SLL_SAT = 3'd5;
  localparam logic [2:0] OP_SGN     = 3'd6;
  localparam logic [2:0] OP_SGN_RND = 3'd7;

  logic [2:0]        amt_u, amt_r, amt_l;
  logic [3:0]        amt_s, neg_mag;
  logic              sgn_op, amt_neg, rnd;
  logic [DATA_W-1:0] nxt;
  logic [LANES-1:0]  lane_ovf;
  logic              unused_hi;

  assign unused_hi = ^rs2[DATA_W-1:4];

  assign amt_u   = use_imm ? imm_amt : rs2[2:0];
  assign amt_s   = rs2[3:0];
  assign sgn_op  = (op == OP_SGN) || (op == OP_SGN_RND);
  assign amt_neg = amt_s[3];
  assign neg_mag = 4'd0 - amt_s;
  assign amt_r   = sgn_op ? (neg_mag[3] ? 3'd7 : neg_mag[2:0]) : amt_u;
  assign amt_l   = sgn_op ? amt_s[2:0] : amt_u;
  assign rnd     = (op == OP_SRA_RND) || (op == OP_SRL_RND) || (op == OP_SGN_RND);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [7:0] a, sra_t, srl_t, sll_t, sat_v, res;
    logic [8:0] ext;
    logic       rbit, ovf_l, ovf;

    assign a     = rs1[8*g +: 8];
    assign ext   = {a, 1'b0};
    assign rbit  = rnd & ext[amt_r];
    assign sra_t = 8'($signed(a) >>> amt_r) + {7'd0, rbit};
    assign srl_t = (a >> amt_r) + {7'd0, rbit};
    assign sll_t = a << amt_l;
    assign ovf_l = 8'($signed(sll_t) >>> amt_l) != a;
    assign sat_v = a[7] ? 8'h80 : 8'h7f;

    always_comb begin
      res = sll_t;
      ovf = 1'b0;
      case (op)
        OP_SRA, OP_SRA_RND: res = sra_t;
        OP_SRL, OP_SRL_RND: res = srl_t;
        OP_SLL:             res = sll_t;
        default: begin
          if (sgn_op && amt_neg) begin
            res = sra_t;
          end else begin
            ovf = ovf_l;
            res = ovf_l ? sat_v : sll_t;
          end
        end
      endcase
    end

    assign nxt[8*g +: 8] = res;
    assign lane_ovf[g]   = ovf;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      sat_flag  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= nxt;
      sat_flag <= (sat_flag & ~sat_clr) | (in_valid & (|lane_ovf));
    end
  end
endmodule

module byte_lane_shifter_chk #(
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [2:0]        op,
  input logic              sat_clr,
  input logic              out_valid,
  input logic [DATA_W-1:0] result,
  input logic              sat_flag
);
  AST_VALID_PIPE: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> out_valid); // R1
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> !out_valid); // R1
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> $stable(result)); // R1
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n) sat_flag && !sat_clr |=> sat_flag); // R8
  AST_FLAG_SRC: assert property (@(posedge clk) disable iff (!rst_n) $rose(sat_flag) |-> $past(in_valid)); // R8
  AST_CLEAR_IDLE: assert property (@(posedge clk) disable iff (!rst_n) sat_clr && !in_valid |=> !sat_flag); // R8
  AST_NO_FLAG_PLAIN: assert property (@(posedge clk) disable iff (!rst_n) in_valid && (op < 3'd5) && (!sat_flag || sat_clr) |=> !sat_flag); // R9
endmodule

bind byte_lane_shifter byte_lane_shifter_chk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .sat_clr(sat_clr),
  .out_valid(out_valid), .result(result), .sat_flag(sat_flag)
);

// File: tb/byte_lane_shifter_tb_top.sv
module byte_lane_shifter_tb_top;
  localparam int DATA_W = 64;
  localparam int LANES  = DATA_W / 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              in_valid = 1'b0;
  logic [2:0]        op = '0;
  logic              use_imm = 1'b0;
  logic [2:0]        imm_amt = '0;
  logic [DATA_W-1:0] rs1 = '0;
  logic [DATA_W-1:0] rs2 = '0;
  logic              sat_clr = 1'b0;
  logic              out_valid;
  logic [DATA_W-1:0] result;
  logic              sat_flag;

  int checks = 0;
  int fails  = 0;
  logic              exp_flag = 1'b0;
  logic [DATA_W-1:0] exp_res  = '0;

  always #5 clk = ~clk;

  byte_lane_shifter #(.DATA_W(DATA_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .use_imm(use_imm),
    .imm_amt(imm_amt), .rs1(rs1), .rs2(rs2), .sat_clr(sat_clr),
    .out_valid(out_valid), .result(result), .sat_flag(sat_flag)
  );

  function automatic logic [8:0] sat_left(input int v, input int s);
    int p;
    p = v * (1 << s);
    if (p > 127 || p < -128) return {1'b1, (v < 0) ? 8'h80 : 8'h7f};
    return {1'b0, 8'(p)};
  endfunction

  function automatic logic [8:0] ref_lane(input logic [2:0] o, input logic [7:0] a,
                                          input logic [3:0] a4, input logic ui,
                                          input logic [2:0] im);
    int s, v, u, n, m;
    s = ui ? int'(im) : int'(a4[2:0]);
    v = int'($signed(a));
    u = int'(a);
    case (o)
      3'd0: return {1'b0, 8'(v >>> s)};
      3'd1: return {1'b0, 8'((v + ((1 << s) >> 1)) >>> s)};
      3'd2: return {1'b0, 8'(u >> s)};
      3'd3: return {1'b0, 8'((u + ((1 << s) >> 1)) >> s)};
      3'd4: return {1'b0, 8'(u << s)};
      3'd5: return sat_left(v, s);
      default: begin
        n = a4[3] ? int'(a4) - 16 : int'(a4);
        if (n >= 0) return sat_left(v, n);
        m = -n;
        if (m == 8) m = 7;
        if (o == 3'd6) return {1'b0, 8'(v >>> m)};
        return {1'b0, 8'((v + ((1 << m) >> 1)) >>> m)};
      end
    endcase
  endfunction

  function automatic string op_tag(input logic [2:0] o);
    case (o)
      3'd0, 3'd2, 3'd4: return "R3";
      3'd1, 3'd3:       return "R4";
      3'd5:             return "R5";
      3'd6:             return "R6";
      default:          return "R7";
    endcase
  endfunction

  task automatic check(input string tag, input logic [DATA_W-1:0] er, input logic ev, input logic ef);
    checks++;
    if (result !== er || out_valid !== ev || sat_flag !== ef) begin
      fails++;
      $display("FAIL %s: result=%h valid=%b flag=%b expected result=%h valid=%b flag=%b",
               tag, result, out_valid, sat_flag, er, ev, ef);
    end
  endtask

  task automatic do_op(input logic [2:0] o, input logic [DATA_W-1:0] d1, input logic [DATA_W-1:0] d2,
                       input logic ui, input logic [2:0] im, input logic clr, input string tag);
    logic ovf_any;
    logic [8:0] r;
    @(negedge clk);
    in_valid = 1'b1; op = o; rs1 = d1; rs2 = d2; use_imm = ui; imm_amt = im; sat_clr = clr;
    ovf_any = 1'b0;
    for (int i = 0; i < LANES; i++) begin
      r = ref_lane(o, d1[8*i +: 8], d2[3:0], ui, im);
      exp_res[8*i +: 8] = r[7:0];
      ovf_any |= r[8];
    end
    exp_flag = (exp_flag & ~clr) | ovf_any;
    @(negedge clk);
    in_valid = 1'b0; sat_clr = 1'b0;
    check(tag, exp_res, 1'b1, exp_flag);
  endtask

  task automatic do_clear();
    @(negedge clk);
    sat_clr = 1'b1;
    exp_flag = 1'b0;
    @(negedge clk);
    sat_clr = 1'b0;
    check("R8 clear", exp_res, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0417));
    repeat (3) @(negedge clk);
    check("R1 reset", '0, 1'b0, 1'b0);
    rst_n = 1'b1;

    do_op(3'd0, {8{8'h80}}, 64'd7, 1'b0, 3'd0, 1'b0, "R3 sra fill");
    check("R3 sra 0x80>>7", {8{8'hff}}, 1'b1, 1'b0);
    do_op(3'd2, {8{8'h80}}, 64'd7, 1'b0, 3'd0, 1'b0, "R3 srl fill");
    check("R3 srl 0x80>>7", {8{8'h01}}, 1'b1, 1'b0);
    do_op(3'd4, 64'h0123_4567_89ab_cdef, 64'hffff_fff0, 1'b1, 3'd4, 1'b0, "R2 imm");
    check("R2 imm left 4", 64'h1030_5070_90b0_d0f0, 1'b1, 1'b0);
    @(negedge clk);
    check("R1 hold", 64'h1030_5070_90b0_d0f0, 1'b0, 1'b0);
    do_op(3'd1, {8{8'h03}}, 64'd1, 1'b0, 3'd0, 1'b0, "R4 round");
    check("R4 round 3>>1", {8{8'h02}}, 1'b1, 1'b0);
    do_op(3'd3, 64'h00ff_7f80_0102_0304, 64'd0, 1'b0, 3'd0, 1'b0, "R4 zero amount");
    check("R4 zero amount", 64'h00ff_7f80_0102_0304, 1'b1, 1'b0);
    do_op(3'd4, {8{8'h40}}, 64'd2, 1'b0, 3'd0, 1'b0, "R9 plain left");
    do_op(3'd5, {4{16'hc040}}, 64'd1, 1'b0, 3'd0, 1'b0, "R5 sat");
    check("R5 sat values", {4{16'h807f}}, 1'b1, 1'b1);
    do_op(3'd0, {8{8'h11}}, 64'd1, 1'b0, 3'd0, 1'b0, "R8 sticky");
    do_clear();
    do_op(3'd6, {8{8'h80}}, 64'h8, 1'b1, 3'd1, 1'b0, "R6 minus eight");
    check("R6 -8 clamps to 7", {8{8'hff}}, 1'b1, 1'b0);
    do_op(3'd6, {8{8'h20}}, 64'h3, 1'b1, 3'd0, 1'b0, "R6 ignore imm");
    check("R6 left 3 sat", {8{8'h7f}}, 1'b1, 1'b1);
    do_op(3'd7, {8{8'h03}}, 64'hf, 1'b0, 3'd0, 1'b0, "R7 round neg");
    check("R7 round -1", {8{8'h02}}, 1'b1, 1'b1);
    do_op(3'd5, {8{8'h7f}}, 64'd1, 1'b0, 3'd0, 1'b1, "R8 clear with overflow");
    do_op(3'd2, {8{8'h7f}}, 64'd1, 1'b0, 3'd0, 1'b1, "R8 clear without overflow");

    for (int k = 0; k < 3000; k++) begin
      logic [2:0] o;
      o = 3'($urandom);
      do_op(o, {$urandom, $urandom}, {$urandom, $urandom}, 1'($urandom), 3'($urandom),
            ($urandom % 8) == 0, op_tag(o));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule